// File: doc/BRIEF.md
# Hardware Page Table Walker

This block services a translation miss entirely in hardware. When the translation cache cannot find a virtual page number, it hands the walker the page number and the identifier of the running process. The walker adds the page number, scaled to the size of one table entry, to the current table base. It then issues a single read on a valid/ready memory request port and waits for a one-cycle response carrying the 32-bit table entry.

The walker checks the entry before anything is installed. A present entry that grants at least one access right becomes a fill for the translation cache: frame number, read right, write right, page number and process identifier, all presented for one cycle. An absent entry, or a present entry that grants no rights, becomes a one-cycle fault report with a cause code instead. For the whole walk the requester is held by a stall output, and no exception is raised for an ordinary miss.

The table base is loaded through its own write port. A write stands for a switch of process, so the walker pulses a context-switch output on the following cycle. The new base applies to walks accepted after the write, and a walk already under way keeps the address it captured.

Top module: `pt_walker`

## Requirements
- R1: After reset, stall, mem_req_valid, fill_valid, fault_valid and ctx_switch are all 0.
- R2: A miss request seen while the walker is idle is accepted at that clock edge. stall is 1 from the next cycle up to and including the cycle in which the fill or fault is presented, and 0 on the cycle after.
- R3: The read address equals the base register value at the moment of acceptance plus the page number times 4. It is held constant with mem_req_valid until mem_req_ready is seen.
- R4: Every walk issues exactly one memory read. mem_req_valid rises on the cycle after acceptance and falls on the cycle after the handshake.
- R5: An entry is laid out as bit 0 present, bit 1 read right, bit 2 write right, bits 31:12 frame number. If it is present and bit 1 or bit 2 is set, fill_valid is 1 for exactly one cycle, the cycle after the response, with fill_ppn = bits 31:12, fill_rd = bit 1, fill_wr = bit 2, and the request's page number and process identifier. fault_valid stays 0.
- R6: An entry with bit 0 clear raises fault_valid for exactly one cycle, the cycle after the response, with fault_cause 0 and the faulting page number and process identifier. No fill is produced.
- R7: An entry with bit 0 set but bits 1 and 2 both clear raises a one-cycle fault with fault_cause 1. No fill is produced.
- R8: Miss requests that arrive while a walk is in progress are ignored. No extra read is issued, and the result belongs to the walk that was accepted.
- R9: A base write sets ctx_switch for exactly the next cycle. Walks accepted later use the new base, and a walk already accepted keeps its old address.
- R10: A response pulse that arrives while no read is outstanding produces no fill and no fault, and leaves stall at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Translation miss request |
| miss_vpn | input | 20 | Missing virtual page number |
| miss_pid | input | 8 | Process identifier of the request |
| stall | output | 1 | Requester must hold while a walk runs |
| base_we | input | 1 | Table base write strobe |
| base_wdata | input | 32 | New table base address |
| ctx_switch | output | 1 | One-cycle pulse after a base write |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | One-cycle read data valid |
| mem_rsp_data | input | 32 | Table entry read back |
| fill_valid | output | 1 | Translation ready for insertion |
| fill_vpn | output | 20 | Page number of the fill |
| fill_pid | output | 8 | Process identifier of the fill |
| fill_ppn | output | 20 | Physical frame number |
| fill_rd | output | 1 | Read right |
| fill_wr | output | 1 | Write right |
| fault_valid | output | 1 | Page fault report |
| fault_vpn | output | 20 | Faulting page number |
| fault_pid | output | 8 | Process identifier of the fault |
| fault_cause | output | 1 | 0 = not present, 1 = no access rights |

## Verification
The hardest cases to reach are a base write that lands in the middle of a walk, and miss requests that pile up while the walker is busy. Both require the stimulus to line up with an internal phase that is visible only through stall. The bench's memory model holds back mem_req_ready for a chosen number of cycles and delays its response, which opens a window of known length. A parallel task then writes the base, or keeps pushing different page numbers, inside that window. The scoreboard expects the address formed from the old base, exactly one read per walk, and only the first walk's result.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    WALK_IDLE  = 2'd0,
    WALK_ISSUE = 2'd1,
    WALK_WAIT  = 2'd2,
    WALK_DONE  = 2'd3
  } walk_state_t;

  typedef enum logic {
    CAUSE_ABSENT    = 1'b0,
    CAUSE_NO_RIGHTS = 1'b1
  } fault_cause_t;

  // Entry field positions (decoded by the translation cache side as well)
  localparam int PTE_PRESENT_BIT = 0;
  localparam int PTE_READ_BIT    = 1;
  localparam int PTE_WRITE_BIT   = 2;
  localparam int PTE_FRAME_LSB   = 12;

endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] base_q,
  output logic              ctx_pulse
);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= '0;
      ctx_pulse <= 1'b0;
    end else begin
      ctx_pulse <= we;
      if (we) base_q <= wdata;
    end
  end

  // R9: a write is followed by a one-cycle switch pulse and the new base
  a_r9_ctx_after_write: assert property (@(posedge clk) disable iff (rst)
    we |=> (ctx_pulse && base_q == $past(wdata)));

  a_r9_ctx_only_after_write: assert property (@(posedge clk) disable iff (rst)
    !we |=> !ctx_pulse);

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int ADDR_W      = 32,
  parameter int VPN_W       = 20,
  parameter int ENTRY_BYTES = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [VPN_W-1:0]  vpn,
  output logic [ADDR_W-1:0] entry_addr
);

  localparam int SHIFT = $clog2(ENTRY_BYTES);
  localparam int IDX_W = VPN_W + SHIFT;

  logic [IDX_W-1:0]  idx_bytes;
  logic [ADDR_W-1:0] offset;

  assign idx_bytes = {vpn, {SHIFT{1'b0}}};

  generate
    if (IDX_W <= ADDR_W) begin : g_extend
      assign offset = {{(ADDR_W-IDX_W){1'b0}}, idx_bytes};
    end else begin : g_truncate
      logic [IDX_W-ADDR_W-1:0] unused_high_idx;
      assign unused_high_idx = idx_bytes[IDX_W-1:ADDR_W];
      assign offset = idx_bytes[ADDR_W-1:0];
    end
  endgenerate

  assign entry_addr = base + offset;

endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
  parameter int PTE_W = 32,
  parameter int PPN_W = 20
) (
  input  logic [PTE_W-1:0] pte,
  output logic             present,
  output logic             can_rd,
  output logic             can_wr,
  output logic             usable,
  output logic             cause,
  output logic [PPN_W-1:0] ppn
);
  import ptw_pkg::*;

  logic unused_pte_bits;
  assign unused_pte_bits = ^pte[PTE_FRAME_LSB-1:PTE_WRITE_BIT+1];

  assign present = pte[PTE_PRESENT_BIT];
  assign can_rd  = pte[PTE_READ_BIT];
  assign can_wr  = pte[PTE_WRITE_BIT];
  assign ppn     = pte[PTE_FRAME_LSB +: PPN_W];
  assign usable  = present && (can_rd || can_wr);
  assign cause   = present ? CAUSE_NO_RIGHTS : CAUSE_ABSENT;

endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm #(
  parameter int ADDR_W = 32,
  parameter int VPN_W  = 20,
  parameter int PID_W  = 8,
  parameter int PPN_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [VPN_W-1:0]  miss_vpn,
  input  logic [PID_W-1:0]  miss_pid,
  input  logic [ADDR_W-1:0] entry_addr,
  output logic              stall,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic              pte_usable,
  input  logic              pte_cause,
  input  logic              pte_rd,
  input  logic              pte_wr,
  input  logic [PPN_W-1:0]  pte_ppn,
  output logic              fill_valid,
  output logic [VPN_W-1:0]  walk_vpn,
  output logic [PID_W-1:0]  walk_pid,
  output logic [PPN_W-1:0]  fill_ppn,
  output logic              fill_rd,
  output logic              fill_wr,
  output logic              fault_valid,
  output logic              fault_cause
);
  import ptw_pkg::*;

  walk_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= WALK_IDLE;
      walk_vpn     <= '0;
      walk_pid     <= '0;
      mem_req_addr <= '0;
      fill_valid   <= 1'b0;
      fill_ppn     <= '0;
      fill_rd      <= 1'b0;
      fill_wr      <= 1'b0;
      fault_valid  <= 1'b0;
      fault_cause  <= 1'b0;
    end else begin
      fill_valid  <= 1'b0;
      fault_valid <= 1'b0;
      unique case (state_q)
        WALK_IDLE: begin
          if (miss_valid) begin
            walk_vpn     <= miss_vpn;
            walk_pid     <= miss_pid;
            mem_req_addr <= entry_addr;
            state_q      <= WALK_ISSUE;
          end
        end
        WALK_ISSUE: begin
          if (mem_req_ready) state_q <= WALK_WAIT;
        end
        WALK_WAIT: begin
          if (mem_rsp_valid) begin
            state_q <= WALK_DONE;
            if (pte_usable) begin
              fill_valid <= 1'b1;
              fill_ppn   <= pte_ppn;
              fill_rd    <= pte_rd;
              fill_wr    <= pte_wr;
            end else begin
              fault_valid <= 1'b1;
              fault_cause <= pte_cause;
            end
          end
        end
        WALK_DONE: state_q <= WALK_IDLE;
        default:   state_q <= WALK_IDLE;
      endcase
    end
  end

  assign stall         = (state_q != WALK_IDLE);
  assign mem_req_valid = (state_q == WALK_ISSUE);

  // R5/R6: a walk ends in either a fill or a fault, never both
  a_r5_fill_or_fault: assert property (@(posedge clk) disable iff (rst)
    !(fill_valid && fault_valid));

  // R6: fault is a single-cycle report
  a_r6_fault_one_cycle: assert property (@(posedge clk) disable iff (rst)
    fault_valid |=> !fault_valid);

  a_r5_fill_one_cycle: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> !fill_valid);

  // R3: request address held while the memory is not ready
  a_r3_addr_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R4: one read per walk
  a_r4_single_read: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  // R2: requester is held whenever a result is presented
  a_r2_stall_on_result: assert property (@(posedge clk) disable iff (rst)
    (fill_valid || fault_valid) |-> stall);

  // R2: result presented, then walker returns to idle
  a_r2_release: assert property (@(posedge clk) disable iff (rst)
    (fill_valid || fault_valid) |=> !stall);

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int ADDR_W      = 32,
  parameter int VPN_W       = 20,
  parameter int PID_W       = 8,
  parameter int PTE_W       = 32,
  parameter int ENTRY_BYTES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                miss_valid,
  input  logic [VPN_W-1:0]    miss_vpn,
  input  logic [PID_W-1:0]    miss_pid,
  output logic                stall,
  input  logic                base_we,
  input  logic [ADDR_W-1:0]   base_wdata,
  output logic                ctx_switch,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [ADDR_W-1:0]   mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [PTE_W-1:0]    mem_rsp_data,
  output logic                fill_valid,
  output logic [VPN_W-1:0]    fill_vpn,
  output logic [PID_W-1:0]    fill_pid,
  output logic [PTE_W-13:0]   fill_ppn,
  output logic                fill_rd,
  output logic                fill_wr,
  output logic                fault_valid,
  output logic [VPN_W-1:0]    fault_vpn,
  output logic [PID_W-1:0]    fault_pid,
  output logic                fault_cause
);
  import ptw_pkg::*;

  localparam int PPN_W = PTE_W - PTE_FRAME_LSB;

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] entry_addr;
  logic              pte_present;
  logic              pte_rd;
  logic              pte_wr;
  logic              pte_usable;
  logic              pte_cause;
  logic [PPN_W-1:0]  pte_ppn;
  logic [VPN_W-1:0]  walk_vpn;
  logic [PID_W-1:0]  walk_pid;
  logic              unused_present;

  assign unused_present = pte_present;

  ptw_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk       (clk),
    .rst       (rst),
    .we        (base_we),
    .wdata     (base_wdata),
    .base_q    (base_q),
    .ctx_pulse (ctx_switch)
  );

  ptw_addr_gen #(
    .ADDR_W      (ADDR_W),
    .VPN_W       (VPN_W),
    .ENTRY_BYTES (ENTRY_BYTES)
  ) u_addr (
    .base       (base_q),
    .vpn        (miss_vpn),
    .entry_addr (entry_addr)
  );

  ptw_pte_decode #(.PTE_W(PTE_W), .PPN_W(PPN_W)) u_dec (
    .pte     (mem_rsp_data),
    .present (pte_present),
    .can_rd  (pte_rd),
    .can_wr  (pte_wr),
    .usable  (pte_usable),
    .cause   (pte_cause),
    .ppn     (pte_ppn)
  );

  ptw_fsm #(
    .ADDR_W (ADDR_W),
    .VPN_W  (VPN_W),
    .PID_W  (PID_W),
    .PPN_W  (PPN_W)
  ) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .miss_valid    (miss_valid),
    .miss_vpn      (miss_vpn),
    .miss_pid      (miss_pid),
    .entry_addr    (entry_addr),
    .stall         (stall),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .pte_usable    (pte_usable),
    .pte_cause     (pte_cause),
    .pte_rd        (pte_rd),
    .pte_wr        (pte_wr),
    .pte_ppn       (pte_ppn),
    .fill_valid    (fill_valid),
    .walk_vpn      (walk_vpn),
    .walk_pid      (walk_pid),
    .fill_ppn      (fill_ppn),
    .fill_rd       (fill_rd),
    .fill_wr       (fill_wr),
    .fault_valid   (fault_valid),
    .fault_cause   (fault_cause)
  );

  assign fill_vpn  = walk_vpn;
  assign fill_pid  = walk_pid;
  assign fault_vpn = walk_vpn;
  assign fault_pid = walk_pid;

  // R10: no result unless a read was handed over before
  a_r10_result_needs_read: assert property (@(posedge clk) disable iff (rst)
    (!stall) |=> !(fill_valid || fault_valid));

endmodule

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        miss_valid = 1'b0;
  logic [19:0] miss_vpn = '0;
  logic [7:0]  miss_pid = '0;
  logic        stall;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        ctx_switch;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        fill_valid;
  logic [19:0] fill_vpn;
  logic [7:0]  fill_pid;
  logic [19:0] fill_ppn;
  logic        fill_rd;
  logic        fill_wr;
  logic        fault_valid;
  logic [19:0] fault_vpn;
  logic [7:0]  fault_pid;
  logic        fault_cause;

  always #2.5 clk = ~clk;

  pt_walker u_pt_walker (.*);

  typedef struct {
    bit          is_fault;
    bit          cause;
    logic [19:0] vpn;
    logic [7:0]  pid;
    logic [19:0] ppn;
    bit          rd;
    bit          wr;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] addr_q[$];
  logic [31:0] mem_model [logic [31:0]];
  logic [31:0] base_model = '0;
  int          checks = 0;
  int          errors = 0;
  int          reads = 0;
  int          ready_lat = 0;
  int          rsp_lat = 0;
  bit          reported = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Memory model: holds ready low for ready_lat cycles, answers after rsp_lat
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        repeat (ready_lat) @(negedge clk);
        mem_req_ready = 1'b1;
        reads++;
        if (addr_q.size() == 0) check(0, "R3 unexpected read", mem_req_addr, 0);
        else begin
          logic [31:0] ea;
          ea = addr_q.pop_front();
          check(mem_req_addr == ea, "R3 entry address", mem_req_addr, ea);
        end
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (rsp_lat) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_model.exists(mem_req_addr) ? mem_model[mem_req_addr] : 32'h0;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = 32'h0;
      end
    end
  end

  // Monitor: pops the scoreboard on every presented result
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && (fill_valid || fault_valid)) begin
        check(stall == 1'b1, "R2 stall held at result", stall, 1);
        if (exp_q.size() == 0) begin
          check(0, "R8/R10 result with nothing outstanding", {fill_valid, fault_valid}, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (e.is_fault) begin
            check(fault_valid && !fill_valid, e.cause ? "R7 fault kind" : "R6 fault kind",
                  {fill_valid, fault_valid}, 2'b01);
            check(fault_cause == e.cause, e.cause ? "R7 cause" : "R6 cause", fault_cause, e.cause);
            check(fault_vpn == e.vpn && fault_pid == e.pid, "R6 fault vpn/pid",
                  {fault_pid, fault_vpn}, {e.pid, e.vpn});
          end else begin
            check(fill_valid && !fault_valid, "R5 fill kind", {fill_valid, fault_valid}, 2'b10);
            check(fill_ppn == e.ppn && fill_rd == e.rd && fill_wr == e.wr, "R5 fill ppn/rights",
                  {fill_ppn, fill_rd, fill_wr}, {e.ppn, e.rd, e.wr});
            check(fill_vpn == e.vpn && fill_pid == e.pid, "R5 fill vpn/pid",
                  {fill_pid, fill_vpn}, {e.pid, e.vpn});
          end
        end
      end
    end
  end

  task automatic walk(input logic [19:0] vpn, input logic [7:0] pid,
                      input int rl, input int sl, input bit poke);
    logic [31:0] a;
    logic [31:0] pte;
    exp_t e;
    @(negedge clk);
    while (stall) @(negedge clk);
    ready_lat = rl;
    rsp_lat   = sl;
    a   = base_model + {10'd0, vpn, 2'b00};
    pte = mem_model.exists(a) ? mem_model[a] : 32'h0;
    e.vpn = vpn; e.pid = pid; e.ppn = pte[31:12]; e.rd = pte[1]; e.wr = pte[2];
    e.is_fault = !(pte[0] && (pte[1] || pte[2]));
    e.cause    = pte[0];
    exp_q.push_back(e);
    addr_q.push_back(a);
    reads = 0;
    miss_valid = 1'b1; miss_vpn = vpn; miss_pid = pid;
    @(negedge clk);
    miss_valid = 1'b0;
    check(stall == 1'b1, "R2 stall after accept", stall, 1);
    check(mem_req_valid == 1'b1, "R4 request after accept", mem_req_valid, 1);
    if (poke) begin
      // R8: extra misses while busy must be ignored
      miss_valid = 1'b1; miss_vpn = vpn ^ 20'h1; miss_pid = pid + 8'd1;
      repeat (2) @(negedge clk);
      miss_valid = 1'b0;
    end
    while (stall) @(negedge clk);
    check(reads == 1, "R4 one read per walk", reads, 1);
    check(exp_q.size() == 0, "R5 result delivered", exp_q.size(), 0);
  endtask

  task automatic set_base(input logic [31:0] b);
    @(negedge clk);
    base_we = 1'b1; base_wdata = b;
    @(negedge clk);
    base_we = 1'b0;
    base_model = b;
    check(ctx_switch == 1'b1, "R9 ctx pulse", ctx_switch, 1);
    @(negedge clk);
    check(ctx_switch == 1'b0, "R9 ctx one cycle", ctx_switch, 0);
  endtask

  initial begin
    #(5.0 * 20000);
    check(0, "watchdog", 0, 1);
    report();
  end

  initial begin
    mem_model[32'h0000_1014] = 32'h0006_4007;
    mem_model[32'h0000_1018] = 32'h000C_8003;
    mem_model[32'h0000_1020] = 32'h0012_3001;
    mem_model[32'h0040_0FFC] = 32'hFFFF_F005;
    mem_model[32'h0000_8014] = 32'h000C_8007;
    mem_model[32'h0000_1030] = 32'h0000_2007;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check({stall, mem_req_valid, fill_valid, fault_valid, ctx_switch} == 5'b0,
          "R1 reset outputs", {stall, mem_req_valid, fill_valid, fault_valid, ctx_switch}, 0);

    set_base(32'h0000_1000);
    walk(20'd5, 8'd1, 0, 0, 0);          // R5 read+write fill, fastest timing
    walk(20'd6, 8'd1, 2, 3, 0);          // R5 read-only fill, delayed memory
    walk(20'd7, 8'd2, 1, 0, 0);          // R6 absent entry
    walk(20'd8, 8'd2, 0, 2, 0);          // R7 present but no rights
    walk(20'hFFFFF, 8'd3, 1, 1, 0);      // R3 top page number, write-only fill
    walk(20'd12, 8'd4, 3, 4, 1);         // R8 misses during walk ignored

    // R9: base written while a walk is in flight
    fork
      walk(20'd5, 8'd1, 4, 2, 0);
      begin @(negedge clk); set_base(32'h0000_8000); end
    join
    walk(20'd5, 8'd9, 0, 1, 0);          // R9 new base gives new frame

    // R10: stray response while idle
    @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_data = 32'h0000_5007;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = 32'h0;
    repeat (3) begin
      @(negedge clk);
      check(!stall && !fill_valid && !fault_valid, "R10 stray response ignored",
            {stall, fill_valid, fault_valid}, 0);
    end
    check(exp_q.size() == 0 && addr_q.size() == 0, "R8 scoreboard drained",
          exp_q.size() + addr_q.size(), 0);
    report();
  end

endmodule